// File: doc/BRIEF.md
# Dual-Clock FIFO with Packet Retransmit

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. A producer pushes words on the write clock and a consumer pops them on the read clock. Four status flags tell each side how much room or data is left. Full and almost-full are registered on the write clock. Empty and almost-empty are registered on the read clock. The full, almost-full and almost-empty levels are inputs, so one instance can serve several packet sizes.

Each pointer crosses into the other domain as Gray code through a two-stage synchronizer. Each side therefore sees the other side's progress a few cycles late. The flags always err toward the safe side: a flag that blocks writes or reads asserts at once, and it clears only a few cycles after the other side has moved.

A rewind input lets the consumer send a packet again. A rewind moves only the read pointer back to the first entry written since the global reset, so stored data can be read out a second time. The write pointer does not move. A single active-low reset, sampled synchronously in both domains, clears both pointers and all flags.

Top module: `dcfifo_rewind`

## Requirements
- R1: While `rst_n` is low (held for at least two edges of each clock), both pointers are cleared, `rd_data` becomes 0, `empty` and `aempty` are 1, and `full` and `afull` are 0.
- R2: A write is accepted only on a write-clock edge where `wr_ce`, `wr_en` and not-`full` are all true. A read is accepted only on a read-clock edge where `rd_ce`, `rd_en` and not-`empty` are all true. Words come out in the order they were written, and `rd_data` takes the new word on the accepting edge.
- R3: `full` is 1 when the write-side occupancy is at least `full_lvl` (legal range 1 to 2^AW-1). `afull` is 1 when that occupancy is at least `afull_lvl` (legal range 1 to `full_lvl`-1). Both flags are registered on the write clock.
- R4: A write attempted while `full` is 1 is ignored: the word is never stored and the write pointer does not move.
- R5: `empty` is 1 when the read-side occupancy is 0 and is registered on the read clock. A read attempted while `empty` is 1 is ignored: the read pointer does not move and `rd_data` holds its value.
- R6: `aempty` is 1 when the read-side occupancy is at most `aempty_lvl` (legal range 1 to `full_lvl`-1). It is registered on the read clock.
- R7: A `rewind` pulse on a read-clock edge with no read request (`rd_ce` and `rd_en` not both 1) sets the read pointer back to the first entry written since the global reset. Later reads return the stored words again from that entry. The write pointer is not changed, so the next word written is read after the words already stored.
- R8: A `rewind` on an edge that also carries a read request is ignored. The read is handled normally and the read pointer advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_ce | input | 1 | Write clock enable |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_ce | input | 1 | Read clock enable |
| rd_en | input | 1 | Read enable |
| rd_data | output | DW | Registered read word |
| rst_n | input | 1 | Global active-low synchronous reset, sampled in both domains |
| rewind | input | 1 | Read-pointer rewind for retransmit (read domain) |
| full_lvl | input | AW | Full threshold |
| afull_lvl | input | AW | Almost-full threshold |
| aempty_lvl | input | AW | Almost-empty threshold |
| full | output | 1 | Full flag (write domain) |
| afull | output | 1 | Almost-full flag (write domain) |
| empty | output | 1 | Empty flag (read domain) |
| aempty | output | 1 | Almost-empty flag (read domain) |

## Verification
The rewind and an ordinary read both act on the read pointer, so they can land on the same read-clock edge. The bench provokes this collision by raising `rewind` together with `rd_ce` and `rd_en` while data is stored. It judges the result by the word returned on that edge and by the next pop, which must return the entry after it and not the first entry. The bench also makes a write while full compete with stored data: it pushes an extra word at the full level, drains the FIFO, and checks that the extra word never comes out and that a read while empty leaves `rd_data` unchanged.

// File: rtl/dcfifo_pkg.sv
// Shared constants for the dual-clock FIFO.
// Assumes: nothing; pure constant definitions.
package dcfifo_pkg;
    // Number of flops in each pointer synchronizer chain
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dcfifo_sync.sv
// Multi-bit synchronizer chain for Gray-coded pointers.
// Assumes: the input changes by at most one bit per source-clock edge,
// so each captured value is either the old or the new pointer.
module dcfifo_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import dcfifo_pkg::*;

    logic [W-1:0] stage [SYNC_STAGES];

    // Shift the pointer through the synchronizer flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[SYNC_STAGES-1];
endmodule

// File: rtl/dcfifo_mem.sv
// Simple dual-port storage: one write port and one registered read port.
// Assumes: the controllers never read an entry in the cycle it is written.
module dcfifo_mem #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 4,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Store an accepted word
    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Register the word for an accepted read
    always_ff @(posedge rd_clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
// Write-side controller: pointer, Gray copy for crossing, full and
// almost-full flags registered from the next-state occupancy.
// Assumes: rd_gray_s is the read pointer synchronized into this domain and
// afull_lvl < full_lvl; occupancy seen here is never below the true value.
module dcfifo_wr_ctrl #(
    parameter int unsigned AW = 4,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] full_lvl,
    input  logic [AW-1:0] afull_lvl,
    input  logic [PW-1:0] rd_gray_s,
    output logic [PW-1:0] wr_gray,
    output logic [AW-1:0] wr_addr,
    output logic          wr_accept,
    output logic          full,
    output logic          afull
);
    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] wr_bin, wr_bin_nxt, rd_bin_s, occ_nxt;

    assign wr_accept  = wr_req & ~full;
    assign wr_bin_nxt = wr_bin + PW'(wr_accept);
    assign rd_bin_s   = from_gray(rd_gray_s);
    assign occ_nxt    = wr_bin_nxt - rd_bin_s;
    assign wr_addr    = wr_bin[AW-1:0];

    // Advance the write pointer and register the write-side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            full    <= 1'b0;
            afull   <= 1'b0;
        end else begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= to_gray(wr_bin_nxt);
            full    <= (occ_nxt >= {1'b0, full_lvl});
            afull   <= (occ_nxt >= {1'b0, afull_lvl});
        end
    end

    // R4: a write attempted while full leaves the pointer where it was
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full) |=> (wr_bin == $past(wr_bin)));

    // R3: with legal thresholds, full always comes with almost-full
    a_r3_full_implies_afull: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> afull);

    // R1: the first write-clock edge after reset sees cleared flags
    a_r1_wr_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!full && !afull && wr_bin == '0));
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
// Read-side controller: pointer with rewind, Gray copy for crossing, empty
// and almost-empty flags registered from the next-state occupancy.
// Assumes: wr_gray_s is the write pointer synchronized into this domain; a
// rewind is used only while at most 2^AW words have been written since
// reset, and writes pause for a few write cycles after it.
module dcfifo_rd_ctrl #(
    parameter int unsigned AW = 4,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rewind,
    input  logic [AW-1:0] aempty_lvl,
    input  logic [PW-1:0] wr_gray_s,
    output logic [PW-1:0] rd_gray,
    output logic [AW-1:0] rd_addr,
    output logic          rd_accept,
    output logic          empty,
    output logic          aempty
);
    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] rd_bin, rd_bin_nxt, wr_bin_s, occ_nxt;
    logic          do_rewind;

    assign rd_accept  = rd_req & ~empty;
    assign do_rewind  = rewind & ~rd_req;
    assign rd_bin_nxt = do_rewind ? '0 : rd_bin + PW'(rd_accept);
    assign wr_bin_s   = from_gray(wr_gray_s);
    assign occ_nxt    = wr_bin_s - rd_bin_nxt;
    assign rd_addr    = rd_bin[AW-1:0];

    // Advance or rewind the read pointer and register the read-side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            empty   <= 1'b1;
            aempty  <= 1'b1;
        end else begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= to_gray(rd_bin_nxt);
            empty   <= (occ_nxt == '0);
            aempty  <= (occ_nxt <= {1'b0, aempty_lvl});
        end
    end

    // R5: a read attempted while empty does not move the pointer
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> (rd_bin == $past(rd_bin)));

    // R7: an unopposed rewind returns the pointer to the start
    a_r7_rewind_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && !rd_req) |=> (rd_bin == '0));

    // R8: a rewind that meets a read does not win; the read advances by one
    a_r8_read_beats_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && rd_req && !empty) |=> (rd_bin == $past(rd_bin) + 1'b1));

    // R6: empty always comes with almost-empty
    a_r6_empty_implies_aempty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> aempty);

    // R1: the first read-clock edge after reset sees cleared flags
    a_r1_rd_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && aempty && rd_bin == '0));
endmodule

// File: rtl/dcfifo_rewind.sv
// Dual-clock FIFO top: ties the write and read controllers, the two
// pointer synchronizers and the storage array together.
// Assumes: rst_n is held low for at least two edges of each clock and
// thresholds lie in their legal ranges (see the requirements).
module dcfifo_rewind #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 4,
    localparam int unsigned PW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_ce,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_ce,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          rst_n,
    input  logic          rewind,
    input  logic [AW-1:0] full_lvl,
    input  logic [AW-1:0] afull_lvl,
    input  logic [AW-1:0] aempty_lvl,
    output logic          full,
    output logic          afull,
    output logic          empty,
    output logic          aempty
);
    logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_accept, rd_accept;

    dcfifo_wr_ctrl #(.AW(AW)) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .wr_req    (wr_ce & wr_en),
        .full_lvl  (full_lvl),
        .afull_lvl (afull_lvl),
        .rd_gray_s (rd_gray_s),
        .wr_gray   (wr_gray),
        .wr_addr   (wr_addr),
        .wr_accept (wr_accept),
        .full      (full),
        .afull     (afull)
    );

    dcfifo_rd_ctrl #(.AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .rd_req     (rd_ce & rd_en),
        .rewind     (rewind),
        .aempty_lvl (aempty_lvl),
        .wr_gray_s  (wr_gray_s),
        .rd_gray    (rd_gray),
        .rd_addr    (rd_addr),
        .rd_accept  (rd_accept),
        .empty      (empty),
        .aempty     (aempty)
    );

    dcfifo_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    dcfifo_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_accept),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .rd_clk (rd_clk),
        .rst_n  (rst_n),
        .re     (rd_accept),
        .raddr  (rd_addr),
        .rdata  (rd_data)
    );
endmodule

// File: tb/dcfifo_rewind_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module dcfifo_rewind_tb_top;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wr_ce = 0, wr_en = 0, rd_ce = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rst_n = 1'b0, rewind = 1'b0;
    logic [AW-1:0] full_lvl = 4'd12, afull_lvl = 4'd10, aempty_lvl = 4'd2;
    logic          full, afull, empty, aempty;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 wclk = ~wclk;   // 200 MHz write clock
    always #3.5 rclk = ~rclk;   // unrelated read clock

    dcfifo_rewind #(.DW(DW), .AW(AW)) dut_i (
        .wr_clk(wclk), .wr_ce(wr_ce), .wr_en(wr_en), .wr_data(wr_data),
        .rd_clk(rclk), .rd_ce(rd_ce), .rd_en(rd_en), .rd_data(rd_data),
        .rst_n(rst_n), .rewind(rewind), .full_lvl(full_lvl),
        .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .full(full), .afull(afull), .empty(empty), .aempty(aempty)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge rclk);
        repeat (4) @(posedge wclk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge rclk) rst_n = 1'b0;
        repeat (4) @(negedge rclk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic push(input logic [DW-1:0] d, input logic ce = 1'b1);
        @(negedge wclk);
        wr_ce = ce; wr_en = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_ce = 1'b0; wr_en = 1'b0;
    endtask

    task automatic pop(output logic [DW-1:0] got, input logic rw = 1'b0);
        @(negedge rclk);
        rd_ce = 1'b1; rd_en = 1'b1; rewind = rw;
        @(posedge rclk);
        #1 got = rd_data;
        @(negedge rclk);
        rd_ce = 1'b0; rd_en = 1'b0; rewind = 1'b0;
    endtask

    // R1: flags and read data after global reset
    task automatic t_reset();
        do_reset();
        check("R1 empty", {7'd0, empty}, 8'd1);
        check("R1 aempty", {7'd0, aempty}, 8'd1);
        check("R1 full", {7'd0, full}, 8'd0);
        check("R1 afull", {7'd0, afull}, 8'd0);
        check("R1 rd_data", rd_data, 8'd0);
    endtask

    // R2: clock enable low blocks a write
    task automatic t_ce_gate();
        push(8'h55, 1'b0);
        settle();
        check("R2 write blocked by wr_ce", {7'd0, empty}, 8'd1);
    endtask

    // R2, R5, R6: ordering and almost-empty boundary
    task automatic t_order();
        logic [DW-1:0] g;
        push(8'h10); push(8'h11);
        settle();
        check("R5 empty clears", {7'd0, empty}, 8'd0);
        check("R6 aempty at level", {7'd0, aempty}, 8'd1);
        push(8'h12);
        settle();
        check("R6 aempty above level", {7'd0, aempty}, 8'd0);
        push(8'h13); push(8'h14);
        for (int i = 0; i < 5; i++) begin
            pop(g);
            check("R2 order", g, 8'h10 + 8'(i));
        end
        settle();
        check("R5 empty after drain", {7'd0, empty}, 8'd1);
        check("R6 aempty after drain", {7'd0, aempty}, 8'd1);
    endtask

    // R3, R4, R5: thresholds, write while full, read while empty
    task automatic t_full();
        logic [DW-1:0] g;
        for (int i = 0; i < 10; i++) push(8'h40 + 8'(i));
        settle();
        check("R3 afull at level", {7'd0, afull}, 8'd1);
        check("R3 full below level", {7'd0, full}, 8'd0);
        push(8'h4A); push(8'h4B);
        settle();
        check("R3 full at level", {7'd0, full}, 8'd1);
        push(8'hEE);
        settle();
        for (int i = 0; i < 12; i++) begin
            pop(g);
            check("R4 data after full", g, 8'h40 + 8'(i));
        end
        settle();
        check("R4 extra word dropped", {7'd0, empty}, 8'd1);
        pop(g);
        check("R5 read while empty holds", g, 8'h4B);
    endtask

    // R7: rewind replays from the first entry, write pointer unchanged
    task automatic t_rewind();
        logic [DW-1:0] g;
        do_reset();
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
        settle();
        pop(g); pop(g);
        check("R7 second word before rewind", g, 8'hA1);
        @(negedge rclk) rewind = 1'b1;
        @(negedge rclk) rewind = 1'b0;
        settle();
        for (int i = 0; i < 4; i++) begin
            pop(g);
            check("R7 replay", g, 8'hA0 + 8'(i));
        end
        settle();
        check("R7 empty after replay", {7'd0, empty}, 8'd1);
        push(8'hB5);
        settle();
        pop(g);
        check("R7 write pointer kept", g, 8'hB5);
    endtask

    // R8: rewind colliding with a read is ignored
    task automatic t_rewind_collide();
        logic [DW-1:0] g;
        do_reset();
        push(8'hC0); push(8'hC1); push(8'hC2);
        settle();
        pop(g);
        pop(g, 1'b1);
        check("R8 read wins collision", g, 8'hC1);
        pop(g);
        check("R8 no rewind after collision", g, 8'hC2);
        settle();
        check("R8 empty after collision", {7'd0, empty}, 8'd1);
    endtask

    initial begin
        t_reset();
        t_ce_gate();
        t_order();
        t_full();
        t_rewind();
        t_rewind_collide();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule